// File: doc/BRIEF.md
# Register-or-Immediate Integer ALU

This block is the purely combinational execute stage of a small 24-bit load/store core. Each cycle the decoder hands it a 4-bit operation code, an operand-source bit and two possible second operands: a register value, or the raw immediate field taken from the instruction word. The block forms the effective second operand, performs one of twelve integer operations and returns a 24-bit result together with a flag that marks an unassigned operation code.

Operand-source bit set means the second operand is the register value. Clear means it is the immediate: the low 10 bits of the immediate field are sign-extended to 24 bits. Operation code 1 is overloaded. With a register operand it subtracts. With an immediate it loads the full 14-bit field into the top of the word. Multiply, multiply-high, unsigned divide and unsigned remainder all complete within the same cycle.

Top module: `rr_alu`

## Requirements
- R1: Code 0 adds operand A to the effective second operand, modulo 2^24. With `use_reg`=0 the effective operand is `imm[9:0]` sign-extended to 24 bits, and an all-zero second operand returns operand A unchanged.
- R2: Code 1 with `use_reg`=1 returns A minus `rb`, modulo 2^24.
- R3: Code 1 with `use_reg`=0 returns `imm[13:0]` in result bits 23:10 and zeros in bits 9:0, whatever A holds.
- R4: Code 2 shifts A left and code 3 shifts A right logically. The shift amount is bits 4:0 of the effective second operand, and any amount of 24 or more gives 0.
- R5: Code 4 shifts A right arithmetically by the same 5-bit amount. Any amount of 24 or more gives 24 copies of A's bit 23.
- R6: Codes 5, 6 and 7 return the bitwise XOR, OR and AND of A and the effective second operand.
- R7: Code 8 returns the low 24 bits of the product.
- R8: Code 9 returns bits 47:24 of the 48-bit product, with both operands treated as two's-complement signed values.
- R9: Code 10 returns the unsigned quotient A / B. A zero divisor returns 24'hFFFFFF.
- R10: Code 11 returns the unsigned remainder A mod B. A zero divisor returns A.
- R11: Codes 12 to 15 raise `illegal` and force the result to 0. Codes 0 to 11 keep `illegal` low.
- R12: With `use_reg`=0 the value on `rb` has no effect on the result. With `use_reg`=1 the value on `imm` has no effect, except for code 1 with `use_reg`=0, which is covered by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (0 add … 11 remainder, 12–15 unassigned) |
| use_reg | input | 1 | 1: second operand is `rb`; 0: second operand comes from `imm` |
| ra | input | 24 | Operand A |
| rb | input | 24 | Register second operand |
| imm | input | 14 | Immediate field from the instruction; bits 9:0 for ALU immediates, all 14 for the upper load |
| result | output | 24 | Operation result |
| illegal | output | 1 | Unassigned operation code |

## Verification
The checker evaluates its properties whenever the inputs change, so it takes for granted that every input holds a known two-state value once the inputs have settled, and that `op` is never left floating. The bench meets this condition in two ways. It drives every input from a single task on the falling clock edge, and it compares results on the rising edge, after the combinational paths have settled. The bounds on quotient and remainder only hold for a nonzero divisor, so the checker guards them with that condition. The bench also sends explicit zero-divisor cases so that the guarded branch is exercised as well.

// File: rtl/rr_alu.sv
module rr_alu #(
  parameter int XLEN   = 24,
  parameter int IMM_W  = 10,
  parameter int UIMM_W = 14
) (
  input  logic [3:0]        op,
  input  logic              use_reg,
  input  logic [XLEN-1:0]   ra,
  input  logic [XLEN-1:0]   rb,
  input  logic [UIMM_W-1:0] imm,
  output logic [XLEN-1:0]   result,
  output logic              illegal
);
  localparam int SHW = $clog2(XLEN);
  localparam int PW  = 2 * XLEN;

  logic [XLEN-1:0] opb;
  assign opb = use_reg ? rb : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm[IMM_W-1:0]};

  logic [SHW-1:0] amt;
  logic           wide;
  assign amt  = opb[SHW-1:0];
  assign wide = 32'(amt) >= XLEN;

  // one right shifter serves all three shifts; left shift works on reversed bits
  logic [XLEN-1:0] ra_rev, sh_in, sh_out_rev;
  logic            is_left, fill;
  assign is_left = (op == 4'd2);
  assign fill    = (op == 4'd4) & ra[XLEN-1];
  assign sh_in   = is_left ? ra_rev : ra;

  logic [XLEN-1:0] stg [SHW+1];
  assign stg[0] = sh_in;
  for (genvar k = 0; k < SHW; k++) begin : g_shift
    localparam int D = 1 << k;
    if (D < XLEN) begin : g_mv
      assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
    end else begin : g_all
      assign stg[k+1] = amt[k] ? {XLEN{fill}} : stg[k];
    end
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign ra_rev[i]     = ra[XLEN-1-i];
    assign sh_out_rev[i] = stg[SHW][XLEN-1-i];
  end

  logic [XLEN-1:0] shift_res;
  assign shift_res = wide ? {XLEN{fill}} : (is_left ? sh_out_rev : stg[SHW]);

  logic [PW-1:0] prod;
  assign prod = {{XLEN{ra[XLEN-1]}}, ra} * {{XLEN{opb[XLEN-1]}}, opb};

  // restoring divider, one row per quotient bit, most significant first
  logic [XLEN-1:0] rem [XLEN+1];
  logic [XLEN-1:0] quo;
  assign rem[0] = '0;
  for (genvar i = 0; i < XLEN; i++) begin : g_div
    logic [XLEN:0] shv, diff;
    assign shv  = {rem[i], ra[XLEN-1-i]};
    assign diff = shv - {1'b0, opb};
    assign quo[XLEN-1-i] = ~diff[XLEN];
    assign rem[i+1] = diff[XLEN] ? shv[XLEN-1:0] : diff[XLEN-1:0];
  end

  always_comb begin
    illegal = 1'b0;
    case (op)
      4'd0:    result = ra + opb;
      4'd1:    result = use_reg ? ra - opb : {imm, {(XLEN-UIMM_W){1'b0}}};
      4'd2,
      4'd3,
      4'd4:    result = shift_res;
      4'd5:    result = ra ^ opb;
      4'd6:    result = ra | opb;
      4'd7:    result = ra & opb;
      4'd8:    result = prod[XLEN-1:0];
      4'd9:    result = prod[PW-1:XLEN];
      4'd10:   result = quo;
      4'd11:   result = rem[XLEN];
      default: begin
        result  = '0;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

module rr_alu_chk #(
  parameter int XLEN   = 24,
  parameter int IMM_W  = 10,
  parameter int UIMM_W = 14
) (
  input logic [3:0]        op,
  input logic              use_reg,
  input logic [XLEN-1:0]   ra,
  input logic [XLEN-1:0]   rb,
  input logic [UIMM_W-1:0] imm,
  input logic [XLEN-1:0]   result,
  input logic              illegal
);
  logic [XLEN-1:0] b2;
  assign b2 = use_reg ? rb : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm[IMM_W-1:0]};

  always_comb begin
    // R11
    illegal_zero_chk: assert (!illegal || result == '0);
    // R3
    upper_low_clear_chk: assert (!(op == 4'd1 && !use_reg) || result[XLEN-UIMM_W-1:0] == '0);
    // R4
    srl_wide_chk: assert (!(op == 4'd3 && 32'(b2[4:0]) >= XLEN) || result == '0);
    // R5
    sra_wide_chk: assert (!(op == 4'd4 && 32'(b2[4:0]) >= XLEN) || result == {XLEN{ra[XLEN-1]}});
    // R9
    divu_bound_chk: assert (!(op == 4'd10 && b2 != '0) ||
                            ({{XLEN{1'b0}}, result} * {{XLEN{1'b0}}, b2}) <= {{XLEN{1'b0}}, ra});
    // R10
    remu_bound_chk: assert (!(op == 4'd11 && b2 != '0) || result < b2);
    // R1
    add_identity_chk: assert (!(op == 4'd0 && b2 == '0) || result == ra);
  end
endmodule

bind rr_alu rr_alu_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .UIMM_W(UIMM_W)) u_chk (
  .op(op), .use_reg(use_reg), .ra(ra), .rb(rb), .imm(imm),
  .result(result), .illegal(illegal)
);

// File: tb/tb_rr_alu.sv
`timescale 1ns/1ps
module tb_rr_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  op = '0;
  logic        use_reg = 1'b0;
  logic [23:0] ra = '0, rb = '0;
  logic [13:0] imm = '0;
  logic [23:0] result;
  logic        illegal;

  rr_alu dut (.op(op), .use_reg(use_reg), .ra(ra), .rb(rb), .imm(imm),
              .result(result), .illegal(illegal));

  typedef struct {
    logic [23:0] res;
    logic        ill;
    string       req;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;

  function automatic item_t model(logic [3:0] o, logic r, logic [23:0] a,
                                  logic [23:0] b, logic [13:0] im, string req);
    item_t it;
    logic [23:0] be;
    logic signed [47:0] sp;
    int n;
    be = r ? b : {{14{im[9]}}, im[9:0]};
    n  = int'(be[4:0]);
    it.ill = 1'b0;
    it.req = req;
    case (o)
      4'd0:  it.res = a + be;
      4'd1:  it.res = r ? a - be : {im, 10'd0};
      4'd2:  it.res = (n >= 24) ? 24'd0 : a << n;
      4'd3:  it.res = (n >= 24) ? 24'd0 : a >> n;
      4'd4:  it.res = (n >= 24) ? {24{a[23]}} : 24'($signed(a) >>> n);
      4'd5:  it.res = a ^ be;
      4'd6:  it.res = a | be;
      4'd7:  it.res = a & be;
      4'd8:  it.res = 24'(a * be);
      4'd9:  begin
               sp = 48'($signed(a)) * 48'($signed(be));
               it.res = sp[47:24];
             end
      4'd10: it.res = (be == 0) ? 24'hFFFFFF : a / be;
      4'd11: it.res = (be == 0) ? a : a % be;
      default: begin it.res = 24'd0; it.ill = 1'b1; end
    endcase
    return it;
  endfunction

  task automatic drive(logic [3:0] o, logic r, logic [23:0] a, logic [23:0] b,
                       logic [13:0] im, string req);
    @(negedge clk);
    op = o; use_reg = r; ra = a; rb = b; imm = im;
    sb.push_back(model(o, r, a, b, im, req));
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res || illegal !== e.ill) begin
        fails++;
        $display("FAIL %s op=%0d r=%0b a=%h b=%h imm=%h: got %h/%0b expected %h/%0b",
                 e.req, op, use_reg, ra, rb, imm, result, illegal, e.res, e.ill);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 24'd0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset-state: got %h/%0b expected 000000/0", result, illegal);
    end
    rst_n = 1'b1;

    drive(4'd0, 1, 24'h123456, 24'h000001, 14'h0, "R1");
    drive(4'd0, 0, 24'h000010, 24'hABCDEF, 14'h3FF, "R1");
    drive(4'd0, 1, 24'hFFFFFF, 24'h000001, 14'h0, "R1");
    drive(4'd1, 1, 24'h000000, 24'h000001, 14'h155, "R2");
    drive(4'd1, 1, 24'h800000, 24'h7FFFFF, 14'h0, "R2");
    drive(4'd1, 0, 24'hFFFFFF, 24'h123456, 14'h3FFF, "R3");
    drive(4'd1, 0, 24'h000000, 24'h000000, 14'h2A5C, "R3");
    drive(4'd2, 1, 24'h000001, 24'd23, 14'h0, "R4");
    drive(4'd2, 1, 24'hFFFFFF, 24'd24, 14'h0, "R4");
    drive(4'd3, 1, 24'h800000, 24'd31, 14'h0, "R4");
    drive(4'd3, 1, 24'h800000, 24'hFFFF21, 14'h0, "R4");
    drive(4'd3, 0, 24'hF00000, 24'h0, 14'h004, "R4");
    drive(4'd4, 1, 24'h800000, 24'd30, 14'h0, "R5");
    drive(4'd4, 1, 24'h800000, 24'd23, 14'h0, "R5");
    drive(4'd4, 1, 24'h400000, 24'd25, 14'h0, "R5");
    drive(4'd5, 1, 24'hF0F0F0, 24'hFF00FF, 14'h0, "R6");
    drive(4'd6, 0, 24'h000100, 24'h0, 14'h200, "R6");
    drive(4'd7, 0, 24'hABCDEF, 24'h0, 14'h1FF, "R6");
    drive(4'd8, 1, 24'hFFFFFF, 24'hFFFFFF, 14'h0, "R7");
    drive(4'd9, 1, 24'hFFFFFF, 24'hFFFFFF, 14'h0, "R8");
    drive(4'd9, 1, 24'h800000, 24'h800000, 14'h0, "R8");
    drive(4'd9, 0, 24'h7FFFFF, 24'h0, 14'h3FF, "R8");
    drive(4'd10, 1, 24'h123456, 24'h0, 14'h0, "R9");
    drive(4'd10, 1, 24'hFFFFFF, 24'h000003, 14'h0, "R9");
    drive(4'd10, 0, 24'hFFFFFF, 24'h0, 14'h3FF, "R9");
    drive(4'd11, 1, 24'h123456, 24'h0, 14'h0, "R10");
    drive(4'd11, 1, 24'hFFFFFF, 24'h000007, 14'h0, "R10");
    for (int c = 12; c < 16; c++) begin
      drive(4'(c), 1, 24'hFFFFFF, 24'hFFFFFF, 14'h3FFF, "R11");
      drive(4'(c), 0, 24'h5A5A5A, 24'h0, 14'h0, "R11");
    end
    for (int k = 0; k < 8; k++) begin
      drive(4'd0, 0, 24'h001000, 24'($urandom), 14'h0C8, "R12");
      drive(4'd6, 1, 24'h000F0F, 24'h330000, 14'($urandom), "R12");
    end
    for (int k = 0; k < 600; k++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      drive(o, 1'($urandom), 24'($urandom), 24'($urandom), 14'($urandom),
            o == 0 ? "R1" : o == 1 ? "R2" : o < 4 ? "R4" : o == 4 ? "R5" :
            o < 8 ? "R6" : o == 8 ? "R7" : o == 9 ? "R8" : o == 10 ? "R9" :
            o == 11 ? "R10" : "R11");
    end
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule